// File: doc/BRIEF.md
# Addressing-Mode Effective Address Unit

This unit sits between the instruction decoder and the execution stage of an 8-bit processor with a 16-bit address space. Once the decoder has classified an instruction, the unit is started with the addressing-mode code, the operand width, a flag that says whether the opcode carried an extra leading page byte, the two index registers and the address of the first byte after the opcode. It then reads the operand bytes one per clock through a simple read port and forms the values the execution stage needs.

Six modes are handled: immediate, direct (page-zero), extended (absolute), indexed through X or Y, inherent (register-only) and relative (conditional branch). When the last operand byte has been taken in, the unit reports the effective address, the immediate operand, the address of the next instruction to execute and the total instruction length, all valid together with a one-cycle done strobe. The inputs are latched when a start is accepted, and the results stay on the outputs until the next start is accepted.

Top module: `amode_ea_unit`

## Requirements
- R1: Immediate mode (mode code 0) reads one operand byte when `wide` is 0 and two when `wide` is 1; `imm_val` is the byte zero-extended, or the two bytes with the first read as the high byte; `eff_addr` equals `pc_in`.
- R2: Direct mode (mode code 1) reads one byte b and sets `eff_addr` to 0x00 in the high byte and b in the low byte.
- R3: Extended mode (mode code 2) reads two bytes and sets `eff_addr` to the first byte as high byte and the second as low byte.
- R4: Indexed mode (mode code 3) reads one byte b and sets `eff_addr` to (Y if `use_y` is 1, otherwise X) plus b as an unsigned value, modulo 65536.
- R5: Inherent mode (mode code 4) makes no read, sets `eff_addr` and `imm_val` to 0 and raises `done` in the cycle right after the accepting clock edge.
- R6: Relative mode (mode code 5) reads one byte b; `br_target` and `eff_addr` equal `pc_in`+1 plus b sign-extended (modulo 65536) when `br_cond` is 1, and `pc_in`+1 when it is 0.
- R7: `instr_len` equals 1 + `prebyte` + the number of operand bytes read; for modes other than relative, `br_target` equals `pc_in` plus the number of operand bytes read, modulo 65536.
- R8: Operand reads are issued one per cycle at consecutive addresses starting at `pc_in`, with `busy` high for exactly those cycles; `done` rises in the cycle after the last byte is captured and lasts exactly one cycle.
- R9: While `rst_n` is low and in the first cycle after it rises, `busy`, `done` and `rd_en` are low.
- R10: A `start` raised while `busy` or `done` is high is ignored: the running operation completes with its own inputs and no further operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin operand processing for a decoded instruction |
| mode | input | 3 | Addressing-mode code (0 imm, 1 direct, 2 extended, 3 indexed, 4 inherent, 5 relative) |
| wide | input | 1 | Immediate operand is 16 bits when 1, 8 bits when 0 |
| prebyte | input | 1 | Opcode carried one extra leading byte |
| use_y | input | 1 | Indexed mode uses Y when 1, X when 0 |
| br_cond | input | 1 | Branch condition for relative mode |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| pc_in | input | 16 | Address of the first byte after the opcode |
| rd_data | input | 8 | Byte returned for `rd_addr` in the same cycle |
| rd_en | output | 1 | Operand read request |
| rd_addr | output | 16 | Operand read address |
| busy | output | 1 | Operand bytes are being read |
| done | output | 1 | One-cycle strobe: all results valid |
| eff_addr | output | 16 | Effective address |
| imm_val | output | 16 | Assembled operand bytes |
| br_target | output | 16 | Address of the next instruction to execute |
| instr_len | output | 3 | Total instruction length in bytes |

## Verification
The bench builds the unit with its defaults, a 16-bit address and 8-bit bytes, since the mode set only makes sense at that pairing. With only 256 values per operand byte, it sweeps every first-byte value through all six modes, both width settings, both prebyte settings, both index registers and both branch outcomes. It moves the start address and index values with the sweep so that page-zero limits, sign extension of negative offsets and wrap past 0xFFFF are all reached. Directed cases add starts during a fetch and during the done cycle.

// File: rtl/amode_ea_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the effective address unit.
// Assumes at most two operand bytes per instruction.
package amode_ea_pkg;

    // Addressing-mode codes as presented by the decoder.
    typedef enum logic [2:0] {
        AM_IMM = 3'd0,
        AM_DIR = 3'd1,
        AM_EXT = 3'd2,
        AM_IDX = 3'd3,
        AM_INH = 3'd4,
        AM_REL = 3'd5
    } amode_t;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } fstate_t;

    // Number of operand bytes that follow the opcode for a mode.
    function automatic logic [1:0] operand_bytes(input logic [2:0] m, input logic w);
        case (m)
            AM_IMM:  operand_bytes = w ? 2'd2 : 2'd1;
            AM_DIR:  operand_bytes = 2'd1;
            AM_EXT:  operand_bytes = 2'd2;
            AM_IDX:  operand_bytes = 2'd1;
            AM_REL:  operand_bytes = 2'd1;
            default: operand_bytes = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/amode_fetch_ctrl.sv
`timescale 1ns/1ps
// Module: operand fetch sequencer.
// Accepts a start only when idle, issues one read per clock at consecutive
// addresses from the base, then holds a single done cycle. Assumes the read
// port returns data combinationally in the cycle of the request.
module amode_fetch_ctrl
    import amode_ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  need,
    input  logic [ADDR_W-1:0] base,
    output logic              accept,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en
);

    fstate_t            state_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]   left_q;

    // Start is honoured only from idle.
    always_comb accept = start && (state_q == ST_IDLE);

    // State, read pointer and remaining-byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            left_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        ptr_q   <= base;
                        left_q  <= need;
                        state_q <= (need == '0) ? ST_DONE : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    ptr_q  <= ptr_q + ADDR_W'(1);
                    left_q <= left_q - CNT_W'(1);
                    if (left_q == CNT_W'(1)) state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode of state into the handshake outputs.
    always_comb begin
        busy    = (state_q == ST_FETCH);
        done    = (state_q == ST_DONE);
        rd_en   = busy;
        rd_addr = ptr_q;
        cap_en  = busy;
    end

endmodule

// File: rtl/amode_operand_asm.sv
`timescale 1ns/1ps
// Module: operand byte assembler.
// Shifts incoming bytes through LANES byte lanes so that the byte read first
// ends up most significant. Cleared when a new operation is accepted.
module amode_operand_asm #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int VAL_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [VAL_W-1:0]  value
);

    logic [BYTE_W-1:0] lane_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_head
            // Newest byte enters the lowest lane.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) lane_q[0] <= '0;
                else if (load)       lane_q[0] <= din;
            end
        end else begin : g_tail
            // Older bytes move one lane up.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) lane_q[i] <= '0;
                else if (load)       lane_q[i] <= lane_q[i-1];
            end
        end
        // Lane i occupies byte position i of the result.
        assign value[i*BYTE_W +: BYTE_W] = lane_q[i];
    end

endmodule

// File: rtl/amode_addr_calc.sv
`timescale 1ns/1ps
// Module: combinational result former.
// From the latched instruction context and the assembled operand it forms
// the effective address, operand value, next-instruction address and length.
// Assumes the assembled operand is exactly ADDR_W bits wide.
module amode_addr_calc
    import amode_ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 3
) (
    input  logic [2:0]        mode_q,
    input  logic              wide_q,
    input  logic              pre_q,
    input  logic              use_y_q,
    input  logic              cond_q,
    input  logic [ADDR_W-1:0] x_q,
    input  logic [ADDR_W-1:0] y_q,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [ADDR_W-1:0] opnd,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] imm_val,
    output logic [ADDR_W-1:0] br_target,
    output logic [LEN_W-1:0]  instr_len
);

    localparam int EXT_W = ADDR_W - BYTE_W;

    logic [1:0]        nbytes;
    logic [BYTE_W-1:0] low_b;
    logic [ADDR_W-1:0] zext_b, sext_b, index_sel, seq_next, after_off;

    // Operand byte views and shared sums.
    always_comb begin
        nbytes    = operand_bytes(mode_q, wide_q);
        low_b     = opnd[BYTE_W-1:0];
        zext_b    = {{EXT_W{1'b0}}, low_b};
        sext_b    = {{EXT_W{low_b[BYTE_W-1]}}, low_b};
        index_sel = use_y_q ? y_q : x_q;
        seq_next  = pc_q + ADDR_W'(nbytes);
        after_off = pc_q + ADDR_W'(1);
    end

    // Per-mode result selection.
    always_comb begin
        eff_addr  = '0;
        imm_val   = opnd;
        br_target = seq_next;
        case (mode_q)
            AM_IMM: eff_addr = pc_q;
            AM_DIR: eff_addr = zext_b;
            AM_EXT: eff_addr = opnd;
            AM_IDX: eff_addr = index_sel + zext_b;
            AM_REL: begin
                br_target = cond_q ? (after_off + sext_b) : after_off;
                eff_addr  = br_target;
            end
            default: begin
                eff_addr = '0;
                imm_val  = '0;
            end
        endcase
    end

    // Length counts the opcode, the optional leading byte and the operands.
    always_comb instr_len = LEN_W'(1) + LEN_W'(pre_q) + LEN_W'(nbytes);

endmodule

// File: rtl/amode_ea_unit.sv
`timescale 1ns/1ps
// Module: effective address unit top.
// Latches the decoded instruction context on an accepted start, sequences
// the operand reads and presents the results with a one-cycle done strobe.
// Results stay valid until the next accepted start.
module amode_ea_unit
    import amode_ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic              wide,
    input  logic              prebyte,
    input  logic              use_y,
    input  logic              br_cond,
    input  logic [ADDR_W-1:0] idx_x,
    input  logic [ADDR_W-1:0] idx_y,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] imm_val,
    output logic [ADDR_W-1:0] br_target,
    output logic [LEN_W-1:0]  instr_len
);

    localparam int LANES = ADDR_W / BYTE_W;
    localparam int OPD_W = BYTE_W * LANES;

    logic              accept, cap_en;
    logic [1:0]        need;
    logic [2:0]        mode_q;
    logic              wide_q, pre_q, use_y_q, cond_q;
    logic [ADDR_W-1:0] x_q, y_q, pc_q;
    logic [OPD_W-1:0]  opnd;

    // Byte count for the request being presented.
    always_comb need = operand_bytes(mode, wide);

    // Instruction context captured on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 3'd0;
            wide_q  <= 1'b0;
            pre_q   <= 1'b0;
            use_y_q <= 1'b0;
            cond_q  <= 1'b0;
            x_q     <= '0;
            y_q     <= '0;
            pc_q    <= '0;
        end else if (accept) begin
            mode_q  <= mode;
            wide_q  <= wide;
            pre_q   <= prebyte;
            use_y_q <= use_y;
            cond_q  <= br_cond;
            x_q     <= idx_x;
            y_q     <= idx_y;
            pc_q    <= pc_in;
        end
    end

    amode_fetch_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (2)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .need    (need),
        .base    (pc_in),
        .accept  (accept),
        .busy    (busy),
        .done    (done),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .cap_en  (cap_en)
    );

    amode_operand_asm #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_asm (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .load  (cap_en),
        .din   (rd_data),
        .value (opnd)
    );

    amode_addr_calc #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .LEN_W  (LEN_W)
    ) u_calc (
        .mode_q    (mode_q),
        .wide_q    (wide_q),
        .pre_q     (pre_q),
        .use_y_q   (use_y_q),
        .cond_q    (cond_q),
        .x_q       (x_q),
        .y_q       (y_q),
        .pc_q      (pc_q),
        .opnd      (ADDR_W'(opnd)),
        .eff_addr  (eff_addr),
        .imm_val   (imm_val),
        .br_target (br_target),
        .instr_len (instr_len)
    );

endmodule

// File: rtl/amode_ea_checker.sv
`timescale 1ns/1ps
// Module: protocol checker for the effective address unit, bound to the top.
module amode_ea_checker #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [LEN_W-1:0]  instr_len,
    input logic [2:0]        mode_q
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    rd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !done && !rd_en));

    // R2
    direct_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == 3'd1) |-> (eff_addr[ADDR_W-1:BYTE_W] == '0));

    // R7
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (instr_len >= LEN_W'(1) && instr_len <= LEN_W'(4)));

    // R10
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind amode_ea_unit amode_ea_checker #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .eff_addr  (eff_addr),
    .instr_len (instr_len),
    .mode_q    (mode_q)
);

// File: tb/test_amode_ea_unit.sv
`timescale 1ns/1ps
// Bench: sweeps operand byte values across all modes and options and
// computes every expected result arithmetically.
module test_amode_ea_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd4;
    logic        wide = 1'b0, prebyte = 1'b0, use_y = 1'b0, br_cond = 1'b0;
    logic [15:0] idx_x = '0, idx_y = '0, pc_in = '0;
    logic [7:0]  rd_data;
    logic        rd_en, busy, done;
    logic [15:0] rd_addr, eff_addr, imm_val, br_target;
    logic [2:0]  instr_len;

    logic [15:0] cur_pc = '0;
    logic [7:0]  cur_b0 = '0, cur_b1 = '0;
    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    // Memory model: the two operand bytes sit at cur_pc and cur_pc+1.
    always_comb begin
        if (rd_addr == cur_pc)                 rd_data = cur_b0;
        else if (rd_addr == cur_pc + 16'd1)    rd_data = cur_b1;
        else                                   rd_data = 8'hEE;
    end

    amode_ea_unit i_amode_ea_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wide(wide),
        .prebyte(prebyte), .use_y(use_y), .br_cond(br_cond), .idx_x(idx_x),
        .idx_y(idx_y), .pc_in(pc_in), .rd_data(rd_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .busy(busy), .done(done), .eff_addr(eff_addr),
        .imm_val(imm_val), .br_target(br_target), .instr_len(instr_len)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One operation with full result and timing checks.
    task automatic run_op(input logic [2:0] m, input bit w, input bit pre,
                          input bit ys, input bit cond, input logic [15:0] pc,
                          input logic [15:0] x, input logic [15:0] y,
                          input logic [7:0] b0, input logic [7:0] b1);
        int n, lat, reads, bcyc;
        logic [15:0] e_eff, e_imm, e_tgt, sx;
        string t;
        t = mode_tag(m);
        n = (m == 3'd0) ? (w ? 2 : 1) : (m == 3'd2) ? 2 : (m == 3'd4) ? 0 : 1;
        e_imm = (n == 0) ? 16'h0 : (n == 1) ? {8'h00, b0} : {b0, b1};
        sx = {{8{b0[7]}}, b0};
        e_tgt = pc + 16'(n);
        case (m)
            3'd0: e_eff = pc;
            3'd1: e_eff = {8'h00, b0};
            3'd2: e_eff = {b0, b1};
            3'd3: e_eff = (ys ? y : x) + {8'h00, b0};
            3'd4: e_eff = 16'h0;
            default: begin
                e_tgt = cond ? (pc + 16'd1 + sx) : (pc + 16'd1);
                e_eff = e_tgt;
            end
        endcase
        @(negedge clk);
        cur_pc = pc; cur_b0 = b0; cur_b1 = b1;
        mode = m; wide = w; prebyte = pre; use_y = ys; br_cond = cond;
        idx_x = x; idx_y = y; pc_in = pc; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0; reads = 0; bcyc = 0;
        while (!done && lat < 8) begin
            if (rd_en) reads++;
            if (busy) bcyc++;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        chk(done == 1'b1, "R8", "done seen", int'(done), 1);
        chk(lat == n, (m == 3'd4) ? "R5" : "R8", "done latency", lat, n);
        chk(reads == n && bcyc == n, "R8", "read/busy cycles", reads, n);
        chk(eff_addr == e_eff, t, "eff_addr", int'(eff_addr), int'(e_eff));
        chk(imm_val == e_imm, t, "imm_val", int'(imm_val), int'(e_imm));
        chk(br_target == e_tgt, (m == 3'd5) ? "R6" : "R7", "br_target",
            int'(br_target), int'(e_tgt));
        chk(instr_len == 3'(1 + int'(pre) + n), "R7", "instr_len",
            int'(instr_len), 1 + int'(pre) + n);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !rd_en, "R9", "in reset", int'({busy, done, rd_en}), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !rd_en, "R9", "after reset", int'({busy, done, rd_en}), 0);

        // Sweep: every first-byte value through all modes and options.
        for (int b = 0; b < 256; b++) begin
            for (int m = 0; m < 6; m++) begin
                for (int p = 0; p < 2; p++) begin
                    run_op(3'(m), b[0], p[0], b[1], b[2],
                           {8'(b), ~8'(b)}, 16'hFF80 + 16'(b),
                           {~8'(b), 8'(b)}, 8'(b), 8'(b) ^ 8'h5A);
                end
            end
        end

        // Wrap corners.
        run_op(3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF, 16'h0, 16'h0, 8'h05, 8'h00);
        run_op(3'd5, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0001, 16'h0, 16'h0, 8'h80, 8'h00);
        run_op(3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1000, 16'hFFFF, 16'h0, 8'hFF, 8'h00);
        run_op(3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1000, 16'h0, 16'hFFF0, 8'h20, 8'h00);
        run_op(3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0, 16'h0, 8'hAB, 8'hCD);

        // R10: starts during fetch and during done are ignored.
        @(negedge clk);
        cur_pc = 16'h4000; cur_b0 = 8'h12; cur_b1 = 8'h34;
        mode = 3'd2; wide = 1'b0; prebyte = 1'b0; pc_in = 16'h4000; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mode = 3'd1; pc_in = 16'h4001;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R10", "done after ignored start", int'(done), 1);
        chk(eff_addr == 16'h1234, "R10", "eff_addr kept", int'(eff_addr), 16'h1234);
        chk(instr_len == 3'd3, "R10", "instr_len kept", int'(instr_len), 3);
        start = 1'b1; mode = 3'd0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(!busy && !done, "R10", "start in done cycle", int'({busy, done}), 0);
        @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !rd_en, "R10", "still idle", int'({busy, done, rd_en}), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule